// File: doc/BRIEF.md
# DMA Descriptor Chain Loader

This block sits beside one DMA channel and refills that channel's configuration from memory. Each node in memory is ten consecutive 32-bit words. A start pulse names the first node. When the transfer engine reports that the current transfer has finished, the loader takes the link word of the active configuration and follows it. A zero link ends the chain. A non-zero link starts a fetch of the next node, and the channel restarts once the whole node has arrived. Pointing the last node back at the first gives an endless circular chain.

The loader also carries out a post-request write for the engine. Each time the engine serves a request, the programmed mask data word is written to the programmed mask address. A typical use is to clear the flag of the peripheral that made the request. Descriptor reads leave through a valid/ready request channel and come back on a valid/ready response channel. Only one read is outstanding at a time. The mask write has its own valid/ready channel. Under back-pressure, a request stays valid with a stable address, and for the mask write with stable data, until ready is seen. Control pins and status pins are plain levels or one-cycle pulses.

Top module: `dll_desc_loader`

## Requirements
- R1: After reset, every configuration output is zero, and `chan_en`, `busy`, `restart`, `chain_end`, `rd_req_valid`, `mw_valid` and all three error bits are low.
- R2: An accepted load from an aligned, non-zero address A issues exactly ten reads, one at a time, to A, A+4, …, A+36 in rising order. A read request that is not accepted keeps `rd_req_valid` high and its address unchanged.
- R3: Node word k (k = 0..9) maps to: 0 `cfg_xfer`, 1 `cfg_blk`, 2 `cfg_src`, 3 `cfg_dst`, 4 `cfg_rpt`, 5 `cfg_link`, 6 `cfg_bus`, 7 reserved (read, then discarded), 8 `cfg_mask_addr`, 9 `cfg_mask_data`.
- R4: The configuration outputs change only on the clock edge that raises the one-cycle `restart` pulse. That edge comes after the tenth response, and it also sets `chan_en`.
- R5: A `xfer_done` pulse while `chan_en` is high and the loader is idle clears `chan_en` and loads from `cfg_link`. If `cfg_link` is zero, the loader instead pulses `chain_end` for one cycle and issues no read.
- R6: A load address whose two low bits are not zero sets `err_align`, leaves `chan_en` low and issues no read.
- R7: A response with `rd_rsp_err` set aborts the load at once. No further reads are issued, the configuration outputs keep their old values, `err_list` is set and `chan_en` stays low.
- R8: A `req_served` pulse with a non-zero `cfg_mask_addr` causes exactly one write of `cfg_mask_data` to `cfg_mask_addr`, held stable while `mw_ready` is low. With a zero mask address, no write is issued. A further pulse that arrives while a write is still waiting is merged into that write.
- R9: A mask write that is accepted with `mw_err` high sets `err_mask`.
- R10: A chain whose last link points back to its first node keeps reloading nodes in chain order.
- R11: `kick` and `xfer_done` are ignored while `busy` is high. An accepted `kick` clears all three error bits, unless the same cycle sets one of them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start pulse: load the node at `kick_addr` |
| kick_addr | input | WORD_W | Address of the first node |
| xfer_done | input | 1 | Pulse from the engine: the current transfer has ended |
| req_served | input | 1 | Pulse from the engine: a request has been served |
| rd_req_valid | output | 1 | Descriptor read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | WORD_W | Byte address of the word being read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Loader waits for a response |
| rd_rsp_data | input | WORD_W | Read data |
| rd_rsp_err | input | 1 | Bus error on this read |
| mw_valid | output | 1 | Mask write valid |
| mw_ready | input | 1 | Mask write accepted |
| mw_addr | output | WORD_W | Mask write address |
| mw_data | output | WORD_W | Mask write data |
| mw_err | input | 1 | Bus error on the accepted mask write |
| chan_en | output | 1 | Channel may run with the current configuration |
| restart | output | 1 | One-cycle pulse: new configuration committed |
| chain_end | output | 1 | One-cycle pulse: a null link ended the chain |
| busy | output | 1 | Descriptor fetch in progress |
| cfg_xfer | output | WORD_W | Transfer control word |
| cfg_blk | output | WORD_W | Block count and length word |
| cfg_src | output | WORD_W | Source address |
| cfg_dst | output | WORD_W | Destination address |
| cfg_rpt | output | WORD_W | Block repeat offsets |
| cfg_link | output | WORD_W | Next node address, zero for none |
| cfg_bus | output | WORD_W | Bus selection word |
| cfg_mask_addr | output | WORD_W | Post-request write address |
| cfg_mask_data | output | WORD_W | Post-request write data |
| err_list | output | 1 | Sticky: descriptor read failed |
| err_align | output | 1 | Sticky: misaligned node address |
| err_mask | output | 1 | Sticky: mask write failed |

## Verification
The bench builds the loader with its default WORD_W of 32. At that width the bench can use byte addresses in a small 64-word memory model, and it can check the four-byte stride and the two-bit alignment test directly. The memory model can throttle `rd_req_ready` and `mw_ready` on alternate cycles, which tests the hold rules under back-pressure. It can also return a bus error on one chosen address, so an abort in the middle of a node can be forced.

// File: rtl/dll_pkg.sv
package dll_pkg;
  localparam int NODE_WORDS = 10;
  localparam int IDX_W      = $clog2(NODE_WORDS);
  localparam int KEPT_WORDS = NODE_WORDS - 1;

  // Position of each word inside a node; the loader decodes this order.
  typedef enum logic [IDX_W-1:0] {
    W_XFER  = 4'd0,
    W_BLK   = 4'd1,
    W_SRC   = 4'd2,
    W_DST   = 4'd3,
    W_RPT   = 4'd4,
    W_LINK  = 4'd5,
    W_BUS   = 4'd6,
    W_RSVD  = 4'd7,
    W_MADDR = 4'd8,
    W_MDATA = 4'd9
  } node_word_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_ADDR = 2'd1,
    F_DATA = 2'd2
  } fetch_st_e;

  // Slot in the packed configuration vector; the reserved word has none.
  function automatic int keep_pos(input int w);
    return (w < int'(W_RSVD)) ? w : w - 1;
  endfunction
endpackage

// File: rtl/dll_fetch.sv
module dll_fetch
  import dll_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] go_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [WORD_W-1:0] cap_data,
  output logic              commit,
  output logic              null_end,
  output logic              bad_align,
  output logic              bus_fail,
  output logic              busy
);
  localparam int BYTES = WORD_W / 8;
  localparam int LSB   = $clog2(BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

  fetch_st_e         st;
  logic [WORD_W-1:0] base;
  logic [IDX_W-1:0]  idx;
  logic              accept_go;
  logic              start;
  logic              rsp_take;

  assign accept_go = (st == F_IDLE) && go;
  assign null_end  = accept_go && (go_addr == '0);
  assign bad_align = accept_go && (go_addr != '0) && (go_addr[LSB-1:0] != '0);
  assign start     = accept_go && !null_end && !bad_align;

  assign rd_req_valid = (st == F_ADDR);
  assign rd_rsp_ready = (st == F_DATA);
  assign rd_req_addr  = base + (WORD_W'(idx) << LSB);

  assign rsp_take = (st == F_DATA) && rd_rsp_valid;
  assign bus_fail = rsp_take && rd_rsp_err;
  assign cap_en   = rsp_take && !rd_rsp_err;
  assign cap_idx  = idx;
  assign cap_data = rd_rsp_data;
  assign commit   = cap_en && (idx == LAST_IDX);
  assign busy     = (st != F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      base <= '0;
      idx  <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          st   <= F_ADDR;
          base <= go_addr;
          idx  <= '0;
        end
        F_ADDR: if (rd_req_ready) st <= F_DATA;
        F_DATA: if (rsp_take) begin
          if (rd_rsp_err || idx == LAST_IDX) begin
            st <= F_IDLE;
          end else begin
            st  <= F_ADDR;
            idx <= idx + 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_rd_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[LSB-1:0] == '0));
endmodule

// File: rtl/dll_cfg_bank.sv
module dll_cfg_bank
  import dll_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_en,
  input  logic [IDX_W-1:0]             cap_idx,
  input  logic [WORD_W-1:0]            cap_data,
  input  logic                         commit,
  output logic [KEPT_WORDS*WORD_W-1:0] cfg_q
);
  for (genvar w = 0; w < NODE_WORDS; w++) begin : g_word
    if (w != int'(W_RSVD)) begin : g_kept
      localparam int P = keep_pos(w);
      logic              hit;
      logic [WORD_W-1:0] shadow_r;
      logic [WORD_W-1:0] cfg_r;
      logic [WORD_W-1:0] nxt;

      assign hit = cap_en && (cap_idx == IDX_W'(w));
      assign nxt = hit ? cap_data : shadow_r;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_r <= '0;
          cfg_r    <= '0;
        end else begin
          if (hit)    shadow_r <= cap_data;
          if (commit) cfg_r    <= nxt;
        end
      end

      assign cfg_q[P*WORD_W +: WORD_W] = cfg_r;
    end
  end
endmodule

// File: rtl/dll_post_mask.sv
module dll_post_mask #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              served,
  input  logic [WORD_W-1:0] mask_addr,
  input  logic [WORD_W-1:0] mask_data,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [WORD_W-1:0] mw_addr,
  output logic [WORD_W-1:0] mw_data,
  input  logic              mw_err,
  output logic              fault
);
  logic pend;
  logic fire;
  logic arm;

  assign fire     = pend && mw_ready;
  assign arm      = served && (mask_addr != '0) && (!pend || fire);
  assign mw_valid = pend;
  assign fault    = fire && mw_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      mw_addr <= '0;
      mw_data <= '0;
    end else if (arm) begin
      pend    <= 1'b1;
      mw_addr <= mask_addr;
      mw_data <= mask_data;
    end else if (fire) begin
      pend <= 1'b0;
    end
  end

  assert_mw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
endmodule

// File: rtl/dll_desc_loader.sv
module dll_desc_loader
  import dll_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [WORD_W-1:0] kick_addr,
  input  logic              xfer_done,
  input  logic              req_served,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [WORD_W-1:0] mw_addr,
  output logic [WORD_W-1:0] mw_data,
  input  logic              mw_err,
  output logic              chan_en,
  output logic              restart,
  output logic              chain_end,
  output logic              busy,
  output logic [WORD_W-1:0] cfg_xfer,
  output logic [WORD_W-1:0] cfg_blk,
  output logic [WORD_W-1:0] cfg_src,
  output logic [WORD_W-1:0] cfg_dst,
  output logic [WORD_W-1:0] cfg_rpt,
  output logic [WORD_W-1:0] cfg_link,
  output logic [WORD_W-1:0] cfg_bus,
  output logic [WORD_W-1:0] cfg_mask_addr,
  output logic [WORD_W-1:0] cfg_mask_data,
  output logic              err_list,
  output logic              err_align,
  output logic              err_mask
);
  localparam int P_XFER  = keep_pos(int'(W_XFER));
  localparam int P_BLK   = keep_pos(int'(W_BLK));
  localparam int P_SRC   = keep_pos(int'(W_SRC));
  localparam int P_DST   = keep_pos(int'(W_DST));
  localparam int P_RPT   = keep_pos(int'(W_RPT));
  localparam int P_LINK  = keep_pos(int'(W_LINK));
  localparam int P_BUS   = keep_pos(int'(W_BUS));
  localparam int P_MADDR = keep_pos(int'(W_MADDR));
  localparam int P_MDATA = keep_pos(int'(W_MDATA));

  logic [KEPT_WORDS*WORD_W-1:0] cfg_all;
  logic                         cap_en;
  logic [IDX_W-1:0]             cap_idx;
  logic [WORD_W-1:0]            cap_data;
  logic                         commit;
  logic                         null_end;
  logic                         bad_align;
  logic                         bus_fail;
  logic                         mask_fault;
  logic                         kick_acc;
  logic                         done_acc;
  logic                         go;
  logic [WORD_W-1:0]            go_addr;

  assign kick_acc = kick && !busy;
  assign done_acc = xfer_done && chan_en && !busy && !kick;
  assign go       = kick_acc || done_acc;
  assign go_addr  = kick ? kick_addr : cfg_link;

  dll_fetch #(.WORD_W(WORD_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .go_addr      (go_addr),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .rd_rsp_err   (rd_rsp_err),
    .cap_en       (cap_en),
    .cap_idx      (cap_idx),
    .cap_data     (cap_data),
    .commit       (commit),
    .null_end     (null_end),
    .bad_align    (bad_align),
    .bus_fail     (bus_fail),
    .busy         (busy)
  );

  dll_cfg_bank #(.WORD_W(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (cap_data),
    .commit   (commit),
    .cfg_q    (cfg_all)
  );

  assign cfg_xfer      = cfg_all[P_XFER*WORD_W  +: WORD_W];
  assign cfg_blk       = cfg_all[P_BLK*WORD_W   +: WORD_W];
  assign cfg_src       = cfg_all[P_SRC*WORD_W   +: WORD_W];
  assign cfg_dst       = cfg_all[P_DST*WORD_W   +: WORD_W];
  assign cfg_rpt       = cfg_all[P_RPT*WORD_W   +: WORD_W];
  assign cfg_link      = cfg_all[P_LINK*WORD_W  +: WORD_W];
  assign cfg_bus       = cfg_all[P_BUS*WORD_W   +: WORD_W];
  assign cfg_mask_addr = cfg_all[P_MADDR*WORD_W +: WORD_W];
  assign cfg_mask_data = cfg_all[P_MDATA*WORD_W +: WORD_W];

  dll_post_mask #(.WORD_W(WORD_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .served    (req_served),
    .mask_addr (cfg_mask_addr),
    .mask_data (cfg_mask_data),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .mw_err    (mw_err),
    .fault     (mask_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      restart   <= 1'b0;
      chain_end <= 1'b0;
      err_list  <= 1'b0;
      err_align <= 1'b0;
      err_mask  <= 1'b0;
    end else begin
      restart   <= commit;
      chain_end <= null_end;
      if (commit)              chan_en <= 1'b1;
      else if (go || bus_fail) chan_en <= 1'b0;
      err_align <= bad_align  || (err_align && !kick_acc);
      err_list  <= bus_fail   || (err_list  && !kick_acc);
      err_mask  <= mask_fault || (err_mask  && !kick_acc);
    end
  end

  assert_cfg_on_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all != $past(cfg_all)) |-> restart);

  assert_restart_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> chan_en);

  assert_align_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_align) |-> !rd_req_valid);

  assert_fail_keeps_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_list) |-> (!chan_en && !restart));
endmodule

// File: tb/tb_dll_desc_loader.sv
module tb_dll_desc_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic [31:0] kick_addr = '0;
  logic        xfer_done = 1'b0;
  logic        req_served = 1'b0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        mw_valid, mw_ready, mw_err;
  logic [31:0] mw_addr, mw_data;
  logic        chan_en, restart, chain_end, busy;
  logic [31:0] cfg_xfer, cfg_blk, cfg_src, cfg_dst, cfg_rpt, cfg_link, cfg_bus;
  logic [31:0] cfg_mask_addr, cfg_mask_data;
  logic        err_list, err_align, err_mask;

  always #4 clk = ~clk;

  dll_desc_loader dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(kick_addr),
    .xfer_done(xfer_done), .req_served(req_served),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mw_err(mw_err),
    .chan_en(chan_en), .restart(restart), .chain_end(chain_end), .busy(busy),
    .cfg_xfer(cfg_xfer), .cfg_blk(cfg_blk), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_rpt(cfg_rpt), .cfg_link(cfg_link), .cfg_bus(cfg_bus),
    .cfg_mask_addr(cfg_mask_addr), .cfg_mask_data(cfg_mask_data),
    .err_list(err_list), .err_align(err_align), .err_mask(err_mask)
  );

  int checks = 0;
  int errors = 0;

  // Memory model: 64 words, one outstanding read, optional alternate-cycle stalls.
  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:255];
  int          rd_cnt = 0;
  int          cyc = 0;
  logic        rd_stall = 1'b0;
  logic        mw_stall = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mw_err_addr = 32'hFFFF_FFFF;
  logic        rsp_pend = 1'b0;
  logic [31:0] rsp_dat = '0;
  logic        rsp_e = 1'b0;
  int          mw_cnt = 0;
  logic [31:0] mw_last_addr = '0;
  logic [31:0] mw_last_data = '0;
  int          rs_cnt = 0;
  int          ce_cnt = 0;
  int          mon_bad = 0;
  logic [287:0] cfg_prev = '0;
  logic [287:0] cfg_now;

  assign cfg_now = {cfg_xfer, cfg_blk, cfg_src, cfg_dst, cfg_rpt, cfg_link, cfg_bus,
                    cfg_mask_addr, cfg_mask_data};

  assign rd_req_ready = !rsp_pend && (!rd_stall || cyc[0]);
  assign rd_rsp_valid = rsp_pend;
  assign rd_rsp_data  = rsp_dat;
  assign rd_rsp_err   = rsp_e;
  assign mw_ready     = !mw_stall || cyc[0];
  assign mw_err       = mw_valid && (mw_addr == mw_err_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rsp_pend <= 1'b0;
    end else if (rd_req_valid && rd_req_ready) begin
      rsp_pend <= 1'b1;
      rsp_dat  <= mem[rd_req_addr[7:2]];
      rsp_e    <= (rd_req_addr == err_addr);
      if (rd_cnt < 256) rd_log[rd_cnt] <= rd_req_addr;
      rd_cnt <= rd_cnt + 1;
    end else if (rsp_pend && rd_rsp_ready) begin
      rsp_pend <= 1'b0;
    end
    if (rst_n && mw_valid && mw_ready) begin
      mw_cnt       <= mw_cnt + 1;
      mw_last_addr <= mw_addr;
      mw_last_data <= mw_data;
    end
  end

  // Pulse counters and the R4 watch: outputs may change only with restart.
  always @(negedge clk) begin
    if (rst_n) begin
      if (restart) rs_cnt <= rs_cnt + 1;
      if (chain_end) ce_cnt <= ce_cnt + 1;
      if (cfg_now != cfg_prev && !restart) mon_bad <= mon_bad + 1;
    end
    cfg_prev <= cfg_now;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [287:0] node_exp(input int bw);
    return {mem[bw], mem[bw+1], mem[bw+2], mem[bw+3], mem[bw+4], mem[bw+5], mem[bw+6],
            mem[bw+8], mem[bw+9]};
  endfunction

  task automatic fill_node(input int bw, input int tag, input logic [31:0] link,
                           input logic [31:0] maddr);
    for (int i = 0; i < 10; i++) mem[bw+i] = 32'hC0DE_0000 | (tag << 8) | i;
    mem[bw+5] = link;
    mem[bw+8] = maddr;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_kick(input logic [31:0] a);
    @(negedge clk);
    kick = 1'b1; kick_addr = a;
    @(negedge clk);
    kick = 1'b0;
    wait_idle();
  endtask

  task automatic do_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    wait_idle();
  endtask

  task automatic do_served();
    @(negedge clk);
    req_served = 1'b1;
    @(negedge clk);
    req_served = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cfg_now == '0, "R1", "cfg after reset", cfg_now, '0);
    check({chan_en, restart, chain_end, busy, rd_req_valid, mw_valid,
           err_list, err_align, err_mask} == '0, "R1", "control after reset",
          {chan_en, restart, chain_end, busy, rd_req_valid, mw_valid,
           err_list, err_align, err_mask}, '0);
  endtask

  task automatic t_first_load();
    int r0 = rd_cnt;
    int s0 = rs_cnt;
    bit ord = 1'b1;
    rd_stall = 1'b1;
    do_kick(32'h40);
    check(rd_cnt - r0 == 10, "R2", "read count", rd_cnt - r0, 10);
    for (int i = 0; i < 10; i++) if (rd_log[r0+i] != 32'h40 + 4*i) ord = 1'b0;
    check(ord, "R2", "read addresses in order", rd_log[r0+9], 32'h64);
    check(cfg_now == node_exp(16), "R3", "node A mapping", cfg_now, node_exp(16));
    check(rs_cnt - s0 == 1 && chan_en, "R4", "restart and enable",
          {rs_cnt - s0, chan_en}, {32'd1, 1'b1});
    rd_stall = 1'b0;
  endtask

  task automatic t_follow();
    int r0;
    int c0 = ce_cnt;
    do_done();
    check(cfg_now == node_exp(32), "R5", "follow link to B", cfg_now, node_exp(32));
    do_done();
    check(cfg_now == node_exp(48), "R5", "follow link to C", cfg_now, node_exp(48));
    r0 = rd_cnt;
    do_done();
    check(ce_cnt - c0 == 1 && !chan_en && rd_cnt == r0, "R5", "null link ends chain",
          {ce_cnt - c0, chan_en, rd_cnt - r0}, {32'd1, 1'b0, 32'd0});
    check(cfg_now == node_exp(48), "R5", "cfg kept at chain end", cfg_now, node_exp(48));
  endtask

  task automatic t_align();
    int r0 = rd_cnt;
    do_kick(32'h42);
    check(err_align && !chan_en && rd_cnt == r0, "R6", "misaligned kick",
          {err_align, chan_en, rd_cnt - r0}, {1'b1, 1'b0, 32'd0});
  endtask

  task automatic t_read_err();
    int r0 = rd_cnt;
    err_addr = 32'h4C;
    do_kick(32'h40);
    check(err_list && !chan_en, "R7", "read error flagged", {err_list, chan_en}, {1'b1, 1'b0});
    check(rd_cnt - r0 == 4, "R7", "reads stop at error", rd_cnt - r0, 4);
    check(cfg_now == node_exp(48), "R7", "old cfg kept", cfg_now, node_exp(48));
    check(!err_align, "R11", "kick clears align error", err_align, 1'b0);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_circular();
    int s0 = rs_cnt;
    mem[37] = 32'h40;
    do_kick(32'h40);
    do_done();
    do_done();
    check(cfg_now == node_exp(16) && rs_cnt - s0 == 3, "R10", "ring returns to A",
          {cfg_now, rs_cnt - s0}, {node_exp(16), 32'd3});
    check(!err_list, "R11", "kick clears list error", err_list, 1'b0);
    mem[37] = 32'hC0;
  endtask

  task automatic t_busy_ignore();
    int r0 = rd_cnt;
    int s0 = rs_cnt;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    @(negedge clk);
    kick = 1'b1; kick_addr = 32'hC0; xfer_done = 1'b1;
    @(negedge clk);
    kick = 1'b0; xfer_done = 1'b0;
    wait_idle();
    check(rd_cnt - r0 == 10 && rs_cnt - s0 == 1, "R11", "inputs ignored while busy",
          {rd_cnt - r0, rs_cnt - s0}, {32'd10, 32'd1});
    check(cfg_now == node_exp(32), "R11", "cfg is B", cfg_now, node_exp(32));
  endtask

  task automatic t_mask();
    int m0 = mw_cnt;
    mw_stall = 1'b1;
    do_served();
    check(mw_cnt - m0 == 1 && mw_last_addr == mem[40] && mw_last_data == mem[41], "R8",
          "mask write", {mw_cnt - m0, mw_last_addr, mw_last_data},
          {32'd1, mem[40], mem[41]});
    check(!mw_valid, "R8", "mask write retired", mw_valid, 1'b0);
    mw_err_addr = mem[40];
    do_served();
    check(err_mask, "R9", "mask write error", err_mask, 1'b1);
    mw_err_addr = 32'hFFFF_FFFF;
    do_done();
    m0 = mw_cnt;
    do_served();
    check(mw_cnt == m0 && !mw_valid, "R8", "zero mask address skips write",
          {mw_cnt - m0, mw_valid}, {32'd0, 1'b0});
    mw_stall = 1'b0;
  endtask

  initial begin
    fill_node(16, 1, 32'h80, 32'h0000_1000);
    fill_node(32, 2, 32'hC0, 32'h0000_2000);
    fill_node(48, 3, 32'h0,  32'h0);
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    for (int i = 26; i < 32; i++) mem[i] = 32'h0;
    for (int i = 42; i < 48; i++) mem[i] = 32'h0;
    for (int i = 58; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_load();
    t_follow();
    t_align();
    t_read_err();
    t_circular();
    t_busy_ignore();
    t_mask();
    check(mon_bad == 0, "R4", "cfg changed only with restart", mon_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule